// File: doc/BRIEF.md
# Sample-Clock Enable Divider with Phase Advance

The block turns a fast input clock into a one-cycle clock-enable pulse that marks the rising edge of a divided sample clock. The divide ratio is 1, 2 or 4. A 3-bit divider control register, written through a simple write strobe, selects the ratio with a one-hot code. When that register holds no valid one-hot code, the ratio comes from a board strap. The strap is a three-level pin that arrives here already decoded into a 2-bit code.

A phase-advance command moves the divided edge one input cycle earlier. Several converters that share one input clock can use it to bring their divided phases into line. The command is carried by a single control bit. Only a write that changes that bit from 0 to 1 launches an advance. The command acts only in divide-by-4 mode, and successive commands add up.

A soft reset clears the divider's phase state and the phase-advance control bit. It leaves the ratio register alone. Only the hard reset returns the ratio register to strap control.

Top module: `clkdiv_slip`

## Requirements
- R1: With the divider register at 3'b001 the ratio is 1, at 3'b010 it is 2, at 3'b100 it is 4.
- R2: With the divider register at 3'b000, or at any other code not listed in R1 (for example 3'b011), the ratio is taken from the strap input.
- R3: Strap code 2'b00 (low) selects ratio 1, 2'b01 (mid) selects 2, 2'b10 (high) selects 4, and the unused code 2'b11 is treated as low (ratio 1).
- R4: `clk_en_o` is high for one input cycle every N cycles, where N is the active ratio. With ratio 1 it is high on every cycle. It reads high while the hard reset is asserted.
- R5: With ratio 4, a phase-advance command shortens the gap from the current enable pulse to the next one from 4 to 3 cycles. The command is a write of bit value 1 issued in the cycle right after a pulse, while the control bit holds 0. Later pulses keep the 4-cycle spacing.
- R6: A phase-advance command launches only when a write of 1 finds the control bit at 0. A write of 1 while the bit already holds 1 leaves the pulse spacing at 4.
- R7: Phase-advance commands accumulate. Each further 0-then-1 sequence shortens one more gap to 3 cycles.
- R8: With ratio 1 or 2, a phase-advance command has no effect on the pulse spacing.
- R9: When the active ratio changes, the internal count restarts. Count the edge that captures the register write as edge 1. An enable pulse is then present after the second clock edge that follows it, and pulses continue at the new spacing.
- R10: A soft reset keeps the divider register value and clears the phase-advance control bit. After it, a single write of 1 launches an advance.
- R11: A hard reset clears the divider register to 3'b000, so the ratio falls back to the strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| soft_rst_i | input | 1 | Synchronous soft reset, active high |
| strap_i | input | 2 | Decoded three-level strap code |
| div_wr_i | input | 1 | Write strobe for the divider register |
| div_data_i | input | 3 | Value written to the divider register |
| slip_wr_i | input | 1 | Write strobe for the phase-advance control bit |
| slip_bit_i | input | 1 | Value written to the phase-advance control bit |
| clk_en_o | output | 1 | One-cycle enable marking each divided clock edge |

## Verification
The spacing between enable pulses is measured for every register code and every strap code, including the unused ones. This tells the one-hot decoding apart from the fallback to the strap. Phase-advance writes are issued right after a pulse in each ratio, and again with the control bit already set. The resulting 3-cycle versus 4-cycle gaps separate true edge detection from level sensitivity, and accumulation from a single shot. Ratio changes, soft reset and hard reset are each followed by a pulse-position and a gap check. These checks show the restart point and which state each reset clears.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_CODE_W = 3;
    localparam int STRAP_W    = 2;
    localparam int MAX_DIV    = 4;
    localparam int CNT_W      = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2
    } ratio_e;

    typedef struct packed {
        logic [DIV_CODE_W-1:0] div;
        logic                  slip;
        logic                  slip_req;
    } ctrl_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ratio_e           ratio;
    } cnt_state_t;

endpackage

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel
    import clkdiv_pkg::*;
(
    input  logic [DIV_CODE_W-1:0] div_code_i,
    input  logic [STRAP_W-1:0]    strap_i,
    output ratio_e                ratio_o
);

    ratio_e strap_ratio;

    always_comb begin
        unique case (strap_i)
            2'b01:   strap_ratio = RATIO_2;
            2'b10:   strap_ratio = RATIO_4;
            default: strap_ratio = RATIO_1;
        endcase
    end

    always_comb begin
        unique case (div_code_i)
            3'b001:  ratio_o = RATIO_1;
            3'b010:  ratio_o = RATIO_2;
            3'b100:  ratio_o = RATIO_4;
            default: ratio_o = strap_ratio;
        endcase
    end

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  soft_rst_i,
    input  logic                  div_wr_i,
    input  logic [DIV_CODE_W-1:0] div_data_i,
    input  logic                  slip_wr_i,
    input  logic                  slip_bit_i,
    output logic [DIV_CODE_W-1:0] div_code_o,
    output logic                  slip_req_o
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.slip_req = 1'b0;
        if (div_wr_i) begin
            st_d.div = div_data_i;
        end
        if (soft_rst_i) begin
            st_d.slip = 1'b0;
        end else if (slip_wr_i) begin
            st_d.slip     = slip_bit_i;
            st_d.slip_req = slip_bit_i && !st_q.slip;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_code_o = st_q.div;
    assign slip_req_o = st_q.slip_req;

    // R10: a soft reset without a write leaves the ratio register unchanged
    p_div_kept_soft_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_i && !div_wr_i) |=> $stable(st_q.div));

    // R6: a launched advance always leaves the control bit set
    p_req_bit_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.slip_req |-> st_q.slip);

    // R6: a write that finds the bit already set never launches an advance
    p_no_relaunch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.slip && !soft_rst_i) |=> !st_q.slip_req);

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   soft_rst_i,
    input  ratio_e ratio_i,
    input  logic   slip_req_i,
    output logic   clk_en_o
);

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'((1 << st_q.ratio) - 1);
    end

    always_comb begin
        st_d       = st_q;
        st_d.ratio = ratio_i;
        if (soft_rst_i || (ratio_i != st_q.ratio)) begin
            st_d.cnt = '0;
        end else if (slip_req_i && (st_q.ratio == RATIO_4)) begin
            st_d.cnt = st_q.cnt + CNT_W'(2);
        end else if (st_q.cnt == limit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, ratio: RATIO_1};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_en_o = (st_q.cnt == '0);

    // R9: a change of ratio is followed by a restart at zero
    p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio_i != st_q.ratio) |=> (st_q.cnt == '0));

    // R4: with ratio 1 the enable is asserted on every cycle
    p_div1_always_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ratio == RATIO_1) |-> clk_en_o);

    // R8: with ratio 2 the count never leaves the range 0..1
    p_div2_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ratio == RATIO_2) |-> (st_q.cnt <= CNT_W'(1)));

    // R5: a launched advance in ratio 4 skips exactly one count position
    p_slip_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_req_i && st_q.ratio == RATIO_4 && ratio_i == RATIO_4 && !soft_rst_i)
        |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_W'(2))));

endmodule

// File: rtl/clkdiv_slip.sv
module clkdiv_slip
    import clkdiv_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  soft_rst_i,
    input  logic [STRAP_W-1:0]    strap_i,
    input  logic                  div_wr_i,
    input  logic [DIV_CODE_W-1:0] div_data_i,
    input  logic                  slip_wr_i,
    input  logic                  slip_bit_i,
    output logic                  clk_en_o
);

    logic [DIV_CODE_W-1:0] div_code;
    logic                  slip_req;
    ratio_e                ratio;

    clkdiv_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .div_wr_i   (div_wr_i),
        .div_data_i (div_data_i),
        .slip_wr_i  (slip_wr_i),
        .slip_bit_i (slip_bit_i),
        .div_code_o (div_code),
        .slip_req_o (slip_req)
    );

    clkdiv_ratio_sel u_sel (
        .div_code_i (div_code),
        .strap_i    (strap_i),
        .ratio_o    (ratio)
    );

    clkdiv_counter u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .ratio_i    (ratio),
        .slip_req_i (slip_req),
        .clk_en_o   (clk_en_o)
    );

endmodule

// File: tb/clkdiv_slip_test.sv
`timescale 1ns/1ps
module clkdiv_slip_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [1:0] strap = 2'b00;
    logic       div_wr = 1'b0;
    logic [2:0] div_data = 3'b000;
    logic       slip_wr = 1'b0;
    logic       slip_bit = 1'b0;
    logic       clk_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    clkdiv_slip uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .soft_rst_i (soft_rst),
        .strap_i    (strap),
        .div_wr_i   (div_wr),
        .div_data_i (div_data),
        .slip_wr_i  (slip_wr),
        .slip_bit_i (slip_bit),
        .clk_en_o   (clk_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_en) break;
        end
    endtask

    // gap from the current pulse to the next one, optionally launching a slip write
    task automatic gap(input bit do_slip, output int g);
        wait_pulse();
        if (do_slip) begin
            slip_wr  = 1'b1;
            slip_bit = 1'b1;
        end
        g = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            g++;
            slip_wr = 1'b0;
            if (clk_en) break;
        end
    endtask

    task automatic write_div(input logic [2:0] code);
        @(negedge clk);
        div_wr   = 1'b1;
        div_data = code;
        @(negedge clk);
        div_wr   = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic write_slip(input bit b);
        @(negedge clk);
        slip_wr  = 1'b1;
        slip_bit = b;
        @(negedge clk);
        slip_wr  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_gap(input string req, input int exp);
        int g;
        gap(1'b0, g);
        check(g == exp, req, g, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(clk_en == 1'b1, "R4 in reset", clk_en, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_register_codes();
        strap = 2'b00;
        write_div(3'b010); expect_gap("R1 code 010", 2);
        write_div(3'b100); expect_gap("R1 code 100", 4);
        expect_gap("R4 steady ratio 4", 4);
        strap = 2'b10;
        write_div(3'b001); expect_gap("R1 code 001", 1);
    endtask

    task automatic t_strap();
        write_div(3'b000);
        strap = 2'b00; repeat (4) @(negedge clk); expect_gap("R3 strap low", 1);
        strap = 2'b01; repeat (4) @(negedge clk); expect_gap("R3 strap mid", 2);
        strap = 2'b10; repeat (4) @(negedge clk); expect_gap("R3 strap high", 4);
        strap = 2'b11; repeat (4) @(negedge clk); expect_gap("R3 strap unused", 1);
        strap = 2'b01;
        write_div(3'b011); expect_gap("R2 invalid code 011", 2);
        strap = 2'b10;
        write_div(3'b110); expect_gap("R2 invalid code 110", 4);
    endtask

    task automatic t_slip_div4();
        int g;
        strap = 2'b00;
        write_div(3'b100);
        write_slip(1'b0);
        gap(1'b1, g); check(g == 3, "R5 slip gap", g, 3);
        expect_gap("R5 spacing after slip", 4);
        gap(1'b1, g); check(g == 4, "R6 write 1 while set", g, 4);
        write_slip(1'b0);
        gap(1'b1, g); check(g == 3, "R7 second slip", g, 3);
        write_slip(1'b0);
        gap(1'b1, g); check(g == 3, "R7 third slip", g, 3);
    endtask

    task automatic t_slip_ignored();
        int g;
        write_div(3'b010);
        write_slip(1'b0);
        gap(1'b1, g); check(g == 2, "R8 slip at ratio 2", g, 2);
        expect_gap("R8 ratio 2 after slip", 2);
        write_div(3'b001);
        write_slip(1'b0);
        gap(1'b1, g); check(g == 1, "R8 slip at ratio 1", g, 1);
    endtask

    task automatic t_ratio_change();
        write_div(3'b100);
        wait_pulse();
        @(negedge clk);
        div_wr   = 1'b1;
        div_data = 3'b010;
        @(negedge clk);
        div_wr   = 1'b0;
        @(negedge clk);
        check(clk_en == 1'b1, "R9 restart pulse", clk_en, 1);
        expect_gap("R9 new spacing", 2);
    endtask

    task automatic t_soft_reset();
        int g;
        strap = 2'b00;
        write_div(3'b100);
        write_slip(1'b1);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        repeat (3) @(negedge clk);
        expect_gap("R10 ratio kept", 4);
        gap(1'b1, g); check(g == 3, "R10 slip bit cleared", g, 3);
    endtask

    task automatic t_hard_reset();
        strap = 2'b01;
        write_div(3'b100);
        t_reset();
        expect_gap("R11 back to strap", 2);
    endtask

    initial begin
        t_reset();
        expect_gap("R4 default ratio 1", 1);
        t_register_codes();
        t_strap();
        t_slip_div4();
        t_slip_ignored();
        t_ratio_change();
        t_soft_reset();
        t_hard_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL R4 watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule